// File: doc/BRIEF.md
# Steerable Tick-Based Watchdog Timer

This block is a one-shot watchdog timer programmed through a single byte-wide control register. Software writes a multiplier and a resolution code; the block then counts slow tick enables (nominally sixteen per second) down to expiry. Any write of the register stores the new value and restarts the count. Any read restarts it from the value already stored. Either access is the "kick" that keeps the watchdog quiet.

When the count runs out, the block raises a sticky timeout flag. It then does one of two things, chosen by the steering bit of the stored byte. With the bit clear it pulses an interrupt for one clock. With the bit set it pulses a system reset request and a strobe that tells a neighbouring calendar block to clear its century bit. In that case it also clears its own control register, which leaves the watchdog disabled. The expiry fires once and the block stays idle until the next restart.

Control byte layout: bit 7 is the steering bit, bits 6:2 are the multiplier M and bits 1:0 are the resolution code R. The timeout is M × 4^R ticks, so it is 1, 4, 16 or 64 ticks times M.

Top module: `wdt_steer`

## Requirements
- R1: After a synchronous active-low reset, `irq_pulse`, `rst_req`, `cent_clr` and `wd_flag` are 0 and `cfg_q` is 0x00.
- R2: A cycle with `reg_wr` high stores `wr_data` so that it shows on `cfg_q` from the next cycle, and it clears `wd_flag`.
- R3: After a restart with multiplier M (bits 6:2) and resolution R (bits 1:0), M nonzero, expiry happens on exactly the (M × 4^R)-th `tick` after the restart, and not earlier. The outputs show it in the cycle after that tick.
- R4: A stored multiplier of zero disables the watchdog whatever the resolution or steering bits are. In that case no number of ticks produces an interrupt, reset request or flag.
- R5: A cycle with `reg_rd` high, and `reg_wr` low, restarts the count from the value in `cfg_q`, leaves `cfg_q` unchanged and clears `wd_flag`.
- R6: On expiry with bit 7 of `cfg_q` clear, `irq_pulse` is high for exactly one cycle, `wd_flag` becomes 1, `rst_req` and `cent_clr` stay 0, and `cfg_q` keeps its value.
- R7: On expiry with bit 7 of `cfg_q` set, `rst_req` and `cent_clr` are both high for exactly one cycle, `cfg_q` becomes 0x00, `wd_flag` becomes 1, and `irq_pulse` stays 0.
- R8: A restart in the same cycle as the tick that would have expired the count wins: no expiry follows from that tick, and the count is reloaded.
- R9: When `reg_wr` and `reg_rd` are both high in one cycle, the written value is stored and used for the reload.
- R10: Each restart yields at most one expiry. After expiry, further ticks produce nothing until the next restart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the control register |
| reg_rd | input | 1 | Read strobe for the control register (restarts the count) |
| wr_data | input | 8 | Byte to store on a write |
| tick | input | 1 | Timebase enable, one clock wide, nominally 16 Hz |
| irq_pulse | output | 1 | One-cycle interrupt on unsteered expiry |
| rst_req | output | 1 | One-cycle system reset request on steered expiry |
| cent_clr | output | 1 | One-cycle strobe to clear the century bit of the calendar block |
| wd_flag | output | 1 | Sticky timeout flag, cleared by any restart |
| cfg_q | output | 8 | Stored control register contents, the value a read returns |

## Verification
Some properties are checked on every cycle. An access is followed by a cleared flag and no expiry, and a write is followed by the stored byte. Every expiry lines up with a tick and with a nonzero multiplier. A steered expiry always comes with a cleared register, the century strobe and the flag. The interrupt never lasts two cycles. Other behaviour only the bench scenarios can show, because it depends on long counts: that expiry lands on exactly the M × 4^R-th tick for each resolution code, that ticks spread unevenly in time still count correctly, that a read reloads a partly used count, and that a disabled or already expired watchdog stays silent over many ticks.

// File: rtl/wdt_pkg.sv
// Package: shared types and helpers for the steerable watchdog.
// Assumes the control byte packs steer | multiplier | resolution from MSB to LSB.
package wdt_pkg;

    // Outcome of a timeout, used by the expiry stage to choose its outputs.
    typedef enum logic [1:0] {
        EXP_NONE  = 2'd0,
        EXP_IRQ   = 2'd1,
        EXP_RESET = 2'd2
    } wdt_exp_e;

    // Counter width needed for the largest multiplier at the coarsest resolution.
    function automatic int cnt_width(input int mult_w, input int res_w);
        return mult_w + 2 * ((1 << res_w) - 1);
    endfunction

    // Classify an expiry from the steering bit.
    function automatic wdt_exp_e classify(input logic hit, input logic steer);
        if (!hit)  return EXP_NONE;
        if (steer) return EXP_RESET;
        return EXP_IRQ;
    endfunction

endpackage

// File: rtl/wdt_cfg_reg.sv
// Module: wdt_cfg_reg
// Holds the watchdog control byte. A write loads new contents. A steered
// expiry clears the byte, which disables the watchdog. A write and a
// self-clear never happen in the same cycle, because any access blocks
// expiry upstream; the write is still given priority for safety.
module wdt_cfg_reg #(
    parameter int CFG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    input  logic             self_clr,
    output logic [CFG_W-1:0] cfg_q
);

    // Control byte storage with synchronous reset, write, and self-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            cfg_q <= wr_data;
        end else if (self_clr) begin
            cfg_q <= '0;
        end
    end

endmodule

// File: rtl/wdt_timeout_calc.sv
// Module: wdt_timeout_calc
// Converts multiplier and resolution fields into a tick count:
// timeout = mult * 4^res. This is purely combinational. A zero multiplier
// gives a zero timeout, which downstream treats as disabled.
module wdt_timeout_calc #(
    parameter int MULT_W = 5,
    parameter int RES_W  = 2,
    parameter int CNT_W  = MULT_W + 2 * ((1 << RES_W) - 1)
) (
    input  logic [MULT_W-1:0] mult,
    input  logic [RES_W-1:0]  res,
    output logic [CNT_W-1:0]  timeout,
    output logic              enabled
);

    localparam int N_RES = 1 << RES_W;
    localparam int PAD_W = CNT_W - MULT_W;

    logic [CNT_W-1:0] cand [N_RES];

    // One shifted copy of the multiplier per resolution code.
    for (genvar g = 0; g < N_RES; g++) begin : g_res
        assign cand[g] = {{PAD_W{1'b0}}, mult} << (2 * g);
    end

    // Select the candidate named by the resolution code.
    always_comb begin
        timeout = '0;
        for (int i = 0; i < N_RES; i++) begin
            if (res == RES_W'(i)) timeout = cand[i];
        end
    end

    // Enabled whenever the multiplier is nonzero.
    assign enabled = |mult;

endmodule

// File: rtl/wdt_counter.sv
// Module: wdt_counter
// One-shot down counter. A load reloads it and arms it when the value is
// nonzero. Each tick decrements it while armed. The tick that takes it from
// one to zero raises the combinational hit output and disarms it. A load
// always wins over a tick in the same cycle.
module wdt_counter #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             load_en,
    input  logic             tick,
    output logic             hit
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt;
    logic             armed;

    // Reload on access, otherwise count ticks down while armed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            armed <= 1'b0;
        end else if (load) begin
            cnt   <= load_en ? load_val : '0;
            armed <= load_en;
        end else if (armed && tick) begin
            cnt <= cnt - ONE;
            if (cnt == ONE) armed <= 1'b0;
        end
    end

    // Final tick of an armed count, unless a reload takes priority.
    assign hit = armed && tick && !load && (cnt == ONE);

endmodule

// File: rtl/wdt_expiry.sv
// Module: wdt_expiry
// Turns a counter hit into the block's outputs. It sets the sticky flag and
// pulses either the interrupt or the reset request with the century strobe,
// as the steering bit decides. A restart clears the flag. Assumes the hit is
// already blocked during a restart.
module wdt_expiry
    import wdt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic steer,
    input  logic restart,
    output logic self_clr,
    output logic irq_pulse,
    output logic rst_req,
    output logic cent_clr,
    output logic wd_flag
);

    wdt_exp_e kind;

    // Decode what kind of expiry, if any, happens this cycle.
    assign kind     = classify(hit, steer);
    assign self_clr = (kind == EXP_RESET);

    // Sticky timeout flag: a restart clears it, an expiry sets it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wd_flag <= 1'b0;
        end else if (restart) begin
            wd_flag <= 1'b0;
        end else if (kind != EXP_NONE) begin
            wd_flag <= 1'b1;
        end
    end

    // Registered one-cycle pulses for the interrupt and the steered reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_pulse <= 1'b0;
            rst_req   <= 1'b0;
            cent_clr  <= 1'b0;
        end else begin
            irq_pulse <= (kind == EXP_IRQ);
            rst_req   <= (kind == EXP_RESET);
            cent_clr  <= (kind == EXP_RESET);
        end
    end

endmodule

// File: rtl/wdt_steer.sv
// Module: wdt_steer (top)
// Byte-programmed watchdog. Any register access restarts the count; a write
// reloads from the new byte, a read from the stored byte. On expiry the
// block raises a flag and either interrupts or requests a reset. Assumes
// tick is a one-clock enable and that strobes are single-cycle qualified.
module wdt_steer #(
    parameter int MULT_W = 5,
    parameter int RES_W  = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      reg_wr,
    input  logic                      reg_rd,
    input  logic [MULT_W+RES_W:0]     wr_data,
    input  logic                      tick,
    output logic                      irq_pulse,
    output logic                      rst_req,
    output logic                      cent_clr,
    output logic                      wd_flag,
    output logic [MULT_W+RES_W:0]     cfg_q
);

    localparam int CFG_W    = MULT_W + RES_W + 1;
    localparam int CNT_W    = wdt_pkg::cnt_width(MULT_W, RES_W);
    localparam int STEER_B  = CFG_W - 1;

    logic             restart;
    logic [CFG_W-1:0] reload_src;
    logic [CNT_W-1:0] timeout;
    logic             tmo_en;
    logic             hit;
    logic             self_clr;

    // Any access restarts the count; a write supplies the fresh value.
    assign restart    = reg_wr || reg_rd;
    assign reload_src = reg_wr ? wr_data : cfg_q;

    wdt_cfg_reg #(.CFG_W(CFG_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .wr_data  (wr_data),
        .self_clr (self_clr),
        .cfg_q    (cfg_q)
    );

    wdt_timeout_calc #(.MULT_W(MULT_W), .RES_W(RES_W), .CNT_W(CNT_W)) u_calc (
        .mult    (reload_src[STEER_B-1:RES_W]),
        .res     (reload_src[RES_W-1:0]),
        .timeout (timeout),
        .enabled (tmo_en)
    );

    wdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (restart),
        .load_val (timeout),
        .load_en  (tmo_en),
        .tick     (tick),
        .hit      (hit)
    );

    wdt_expiry u_exp (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit       (hit),
        .steer     (cfg_q[STEER_B]),
        .restart   (restart),
        .self_clr  (self_clr),
        .irq_pulse (irq_pulse),
        .rst_req   (rst_req),
        .cent_clr  (cent_clr),
        .wd_flag   (wd_flag)
    );

endmodule

// File: rtl/wdt_steer_chk.sv
// Module: wdt_steer_chk
// Port-level temporal checks for wdt_steer, attached by bind.
module wdt_steer_chk #(
    parameter int MULT_W = 5,
    parameter int RES_W  = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  reg_wr,
    input logic                  reg_rd,
    input logic [MULT_W+RES_W:0] wr_data,
    input logic                  tick,
    input logic                  irq_pulse,
    input logic                  rst_req,
    input logic                  cent_clr,
    input logic                  wd_flag,
    input logic [MULT_W+RES_W:0] cfg_q
);

    localparam int CFG_W = MULT_W + RES_W + 1;

    AST_WR_STORES: assert property (@(posedge clk) disable iff (!rst_n) reg_wr |=> cfg_q == $past(wr_data)); // R2
    AST_WR_WINS_RD: assert property (@(posedge clk) disable iff (!rst_n) (reg_wr && reg_rd) |=> cfg_q == $past(wr_data)); // R9
    AST_RD_KEEPS_CFG: assert property (@(posedge clk) disable iff (!rst_n) (reg_rd && !reg_wr) |=> $stable(cfg_q)); // R5
    AST_ACCESS_CLRS_FLAG: assert property (@(posedge clk) disable iff (!rst_n) (reg_wr || reg_rd) |=> !wd_flag); // R5
    AST_ACCESS_BLOCKS_EXP: assert property (@(posedge clk) disable iff (!rst_n) (reg_wr || reg_rd) |=> !(irq_pulse || rst_req)); // R8
    AST_EXP_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n) (irq_pulse || rst_req) |-> $past(tick)); // R3
    AST_EXP_NEEDS_MULT: assert property (@(posedge clk) disable iff (!rst_n) (irq_pulse || rst_req) |-> $past(cfg_q[CFG_W-2:RES_W]) != '0); // R4
    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) irq_pulse |=> !irq_pulse); // R6
    AST_IRQ_UNSTEERED: assert property (@(posedge clk) disable iff (!rst_n) irq_pulse |-> !cfg_q[CFG_W-1] && !rst_req && !cent_clr && wd_flag); // R6
    AST_RST_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) rst_req |-> cfg_q == '0 && cent_clr && wd_flag && !irq_pulse); // R7
    AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) rst_req |=> !rst_req); // R7
    AST_CENT_WITH_RST: assert property (@(posedge clk) disable iff (!rst_n) cent_clr |-> rst_req); // R7
    AST_FLAG_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $rose(wd_flag) |-> (irq_pulse || rst_req)); // R10

endmodule

bind wdt_steer wdt_steer_chk #(.MULT_W(MULT_W), .RES_W(RES_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .wr_data   (wr_data),
    .tick      (tick),
    .irq_pulse (irq_pulse),
    .rst_req   (rst_req),
    .cent_clr  (cent_clr),
    .wd_flag   (wd_flag),
    .cfg_q     (cfg_q)
);

// File: tb/wdt_steer_bench.sv
module wdt_steer_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       tick = 1'b0;
    logic       irq_pulse, rst_req, cent_clr, wd_flag;
    logic [7:0] cfg_q;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    wdt_steer u_wdt_steer (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .wr_data(wr_data), .tick(tick), .irq_pulse(irq_pulse),
        .rst_req(rst_req), .cent_clr(cent_clr), .wd_flag(wd_flag), .cfg_q(cfg_q)
    );

    // Expected tick count from the requirement: M * 4^R, 0 means disabled.
    function automatic int exp_ticks(input logic [7:0] b);
        return int'(b[6:2]) << (2 * int'(b[1:0]));
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] v);
        @(negedge clk); reg_wr = 1'b1; wr_data = v;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic do_read();
        @(negedge clk); reg_rd = 1'b1;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    // Issue n ticks (gapped randomly if gap), record the tick index of the first expiry.
    task automatic run_ticks(input int n, input bit gap, output int first,
                             output int n_irq, output int n_rst, output int n_cent);
        int sent = 0;
        int idle = 0;
        first = 0; n_irq = 0; n_rst = 0; n_cent = 0;
        while (idle < 4) begin
            @(negedge clk);
            if (irq_pulse) n_irq++;
            if (rst_req)   n_rst++;
            if (cent_clr)  n_cent++;
            if ((irq_pulse || rst_req) && first == 0) first = sent;
            if (sent < n) begin
                tick = gap ? 1'($urandom % 2) : 1'b1;
                sent += int'(tick);
            end else begin
                tick = 1'b0;
                idle++;
            end
        end
        tick = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int f, ni, nr, nc;
        logic [7:0] v;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!irq_pulse && !rst_req && !cent_clr && !wd_flag, "R1 outputs", int'({irq_pulse,rst_req,cent_clr,wd_flag}), 0);
        chk(cfg_q == 8'h00, "R1 cfg", cfg_q, 0);

        // R3 R6 R10: M=1 R=1 -> 4 ticks, interrupt once
        do_write(8'h05);
        chk(cfg_q == 8'h05, "R2 store", cfg_q, 5);
        run_ticks(12, 1'b0, f, ni, nr, nc);
        chk(f == 4, "R3 expiry tick 0x05", f, 4);
        chk(ni == 1 && nr == 0 && nc == 0, "R6 irq only once", ni*100+nr*10+nc, 100);
        chk(wd_flag == 1'b1, "R6 flag set", wd_flag, 1);
        chk(cfg_q == 8'h05, "R6 cfg kept", cfg_q, 5);
        run_ticks(20, 1'b0, f, ni, nr, nc);
        chk(ni == 0 && nr == 0, "R10 no re-expiry", ni + nr, 0);

        // R2 write clears flag
        do_write(8'h0C);
        chk(wd_flag == 1'b0, "R2 flag cleared", wd_flag, 0);
        chk(cfg_q == 8'h0C, "R2 store 0x0C", cfg_q, 12);

        // R5 read reloads a partly used count (T=3)
        run_ticks(2, 1'b0, f, ni, nr, nc);
        do_read();
        chk(cfg_q == 8'h0C, "R5 cfg unchanged", cfg_q, 12);
        run_ticks(6, 1'b0, f, ni, nr, nc);
        chk(f == 3 && ni == 1, "R5 reload from stored", f, 3);
        do_read();
        chk(wd_flag == 1'b0, "R5 read clears flag", wd_flag, 0);

        // R7 steered expiry: M=1 R=0
        do_write(8'h84);
        run_ticks(4, 1'b0, f, ni, nr, nc);
        chk(f == 1 && nr == 1 && nc == 1 && ni == 0, "R7 reset path", nr*100+nc*10+ni, 110);
        chk(cfg_q == 8'h00, "R7 cfg cleared", cfg_q, 0);
        chk(wd_flag == 1'b1, "R7 flag set", wd_flag, 1);

        // R4 disabled encodings
        do_write(8'h00);
        run_ticks(80, 1'b0, f, ni, nr, nc);
        chk(ni + nr + nc == 0 && !wd_flag, "R4 zero byte", ni + nr + nc, 0);
        do_write(8'h03);
        run_ticks(80, 1'b0, f, ni, nr, nc);
        chk(ni + nr + nc == 0 && !wd_flag, "R4 mult zero res3", ni + nr + nc, 0);
        do_write(8'h82);
        run_ticks(80, 1'b0, f, ni, nr, nc);
        chk(ni + nr + nc == 0 && cfg_q == 8'h82, "R4 mult zero steered", ni + nr + nc, 0);

        // R8 restart on the final tick (T=2)
        do_write(8'h08);
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b1; reg_wr = 1'b1; wr_data = 8'h08;
        @(negedge clk); tick = 1'b0; reg_wr = 1'b0;
        chk(!irq_pulse && !rst_req, "R8 no expiry on collision", irq_pulse, 0);
        run_ticks(4, 1'b0, f, ni, nr, nc);
        chk(f == 2 && ni == 1, "R8 reloaded count", f, 2);

        // R9 simultaneous read and write
        do_write(8'h04);
        @(negedge clk); reg_wr = 1'b1; reg_rd = 1'b1; wr_data = 8'h10;
        @(negedge clk); reg_wr = 1'b0; reg_rd = 1'b0;
        chk(cfg_q == 8'h10, "R9 write wins", cfg_q, 16);
        run_ticks(8, 1'b0, f, ni, nr, nc);
        chk(f == 4, "R9 reload uses write", f, 4);

        // R3 coarse resolutions
        do_write(8'h06);
        run_ticks(20, 1'b1, f, ni, nr, nc);
        chk(f == 16, "R3 res2", f, 16);
        do_write(8'h07);
        run_ticks(70, 1'b0, f, ni, nr, nc);
        chk(f == 64, "R3 res3", f, 64);

        // R3 R6 R7 random configurations with gapped ticks
        for (int k = 0; k < 30; k++) begin
            v = 8'($urandom);
            v[6:2] = 5'(1 + ($urandom % 31));
            v[1:0] = 2'($urandom % 3);
            do_write(v);
            run_ticks(exp_ticks(v) + 3, 1'b1, f, ni, nr, nc);
            chk(f == exp_ticks(v), "R3 random timeout", f, exp_ticks(v));
            if (v[7]) chk(nr == 1 && nc == 1 && ni == 0 && cfg_q == 8'h00, "R7 random steer", nr*100+nc*10+ni, 110);
            else      chk(ni == 1 && nr == 0 && cfg_q == v, "R6 random irq", ni*10+nr, 10);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule